// File: doc/BRIEF.md
# PCI Power State Controller

This block keeps track of which power state a PCI network device is in. It follows the device through full power loss, a sleep state kept alive by auxiliary power only, a sleep state chosen by software, a powered state that is waiting for configuration, and full operation. The state is decided by four things: the auxiliary-power detect, main power-good, the PCI reset, and the two-bit power state field that the host writes. Whenever the block leaves the power-off state it raises a one-cycle internal power-on reset. It also drives the PHY power-down and PHY reset controls and a MAC enable, and it turns decoded wake pulses into an active-low interrupt and an active-low PME output.

All pins are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake. Every output is taken from a register, and each one changes only on a rising clock edge.

State codes on `pwr_state`:

| State | Code |
|---|---|
| power off | 0 |
| cold sleep | 1 |
| hot sleep | 2 |
| D0 uninitialised | 3 |
| D0 active | 4 |

Power field codes: 00 is D0, 11 is D3, and 01 and 10 are reserved. On `en_wdata`, bit 0 is the PME enable and bit 1 is the interrupt enable.

Top module: `pci_pwr_ctl`

## Requirements
- R1: While `rst_n` is low and just after it is released, the outputs are: `pwr_state`=0, `phy_pd`=1, `mac_en`=0, `por`=0, `int_n`=1, `pme_n`=1.
- R2: In state 0, if `aux_det` or `main_ok` is high, the next edge moves the block to state 1. `por` is high for exactly that first cycle, and `phy_pd` stays 1.
- R3: State 1 moves to state 3 one edge after `main_ok` and `pci_rst_n` are both high. It stays in state 1 while either of them is low.
- R4: In state 3, `phy_pd`=0 and `mac_en`=0. `mac_en` is 1 only in state 4.
- R5: A `cfg_done` pulse in state 3 sets a configured flag on the next edge, and the block enters state 4 on the edge after that. The flag is cleared whenever the block is outside states 3 and 4.
- R6: A write (`ps_wr`) of 11 in state 3 or state 4, with `main_ok` high, gives state 2 on the next edge, and `ps_rdata` then reads 11.
- R7: A write of 00 in state 2 returns the block to state 3. In states 3 and 4, `ps_rdata` always reads 00.
- R8: Writes of 01 or 10 are ignored. The state and `ps_rdata` stay unchanged.
- R9: In state 2, 3 or 4, if `main_ok` falls while `aux_det` is high, the next edge gives state 1, and `phy_rst` is high for that one cycle.
- R10: From any state, if `main_ok` and `aux_det` are both low, the next edge gives state 0.
- R11: A wake pulse (`wake_mac` or `wake_phy`) drives `pme_n` low on the next edge if the PME enable is set and the state is not 0. `pme_n` stays low until `wake_clr` is asserted.
- R12: A wake pulse drives `int_n` low on the next edge only in state 4 with the interrupt enable set. `int_n` stays low until `wake_clr` is asserted.
- R13: The internal power-on reset clears both enables, the PME and interrupt status, and the configured flag. After a power-on reset, a wake pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| aux_det | input | 1 | Auxiliary power present |
| main_ok | input | 1 | Main power good |
| pci_rst_n | input | 1 | PCI bus reset, active low |
| ps_wr | input | 1 | Power field write strobe |
| ps_wdata | input | 2 | Power field write value |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 2 | Bit 0 is the PME enable, bit 1 is the interrupt enable |
| cfg_done | input | 1 | Host configuration finished (pulse) |
| wake_mac | input | 1 | Decoded MAC wake event (pulse) |
| wake_phy | input | 1 | Decoded PHY link change (pulse) |
| wake_clr | input | 1 | Clears PME and interrupt status |
| pwr_state | output | 3 | Current state code |
| ps_rdata | output | 2 | Power field read-back |
| por | output | 1 | Internal power-on reset pulse |
| phy_pd | output | 1 | PHY general power-down |
| phy_rst | output | 1 | PHY reset pulse |
| mac_en | output | 1 | MAC transmit/receive enable |
| int_n | output | 1 | Interrupt, active low |
| pme_n | output | 1 | PME, active low |

## Verification
Most results appear one edge after their stimulus: state moves, `ps_rdata`, `por`, `phy_rst`, `int_n` and `pme_n`. The move from state 3 to state 4 after `cfg_done` takes two edges, because the configured flag is registered first. The enables and the clearing done by the power-on reset take effect one edge after they are written or pulsed. The driver applies a stimulus, waits for the edge where its result is due, and only then queues the expected values. The monitor compares that queue at the falling edge that follows, so every comparison lands mid-cycle in the exact cycle the result is due.

// File: rtl/pwr_pkg.sv
`timescale 1ns/1ps
package pwr_pkg;
  localparam int STW = 3;
  localparam int PSW = 2;
  localparam int ENW = 2;

  typedef enum logic [STW-1:0] {
    PS_OFF  = 3'd0,
    PS_COLD = 3'd1,
    PS_HOT  = 3'd2,
    PS_D0U  = 3'd3,
    PS_D0A  = 3'd4
  } pwr_st_e;

  localparam logic [PSW-1:0] FLD_D0 = 2'b00;
  localparam logic [PSW-1:0] FLD_D3 = 2'b11;
  localparam int EN_PME = 0;
  localparam int EN_IRQ = 1;
endpackage

// File: rtl/pwr_fields.sv
`timescale 1ns/1ps
module pwr_fields
  import pwr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           por,
  input  pwr_st_e        st,
  input  logic           ps_wr,
  input  logic [PSW-1:0] ps_wdata,
  input  logic           en_wr,
  input  logic [ENW-1:0] en_wdata,
  input  logic           cfg_done,
  output logic           go_d3,
  output logic           go_d0,
  output logic [PSW-1:0] ps_q,
  output logic           cfg_q,
  output logic [ENW-1:0] en_q
);
  logic reachable;
  logic legal_wr;

  assign reachable = (st == PS_HOT) || (st == PS_D0U) || (st == PS_D0A);
  assign legal_wr  = reachable && ps_wr && ((ps_wdata == FLD_D0) || (ps_wdata == FLD_D3));
  assign go_d3     = legal_wr && (ps_wdata == FLD_D3) && (st != PS_HOT);
  assign go_d0     = legal_wr && (ps_wdata == FLD_D0) && (st == PS_HOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= FLD_D0;
      cfg_q <= 1'b0;
      en_q  <= '0;
    end else begin
      if (por || st == PS_COLD)  ps_q <= FLD_D0;
      else if (legal_wr)         ps_q <= ps_wdata;

      if (por || !(st == PS_D0U || st == PS_D0A)) cfg_q <= 1'b0;
      else if (st == PS_D0U && cfg_done)          cfg_q <= 1'b1;

      if (por)                        en_q <= '0;
      else if (en_wr && st != PS_OFF) en_q <= en_wdata;
    end
  end
endmodule

// File: rtl/pwr_fsm.sv
`timescale 1ns/1ps
module pwr_fsm
  import pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    aux_det,
  input  logic    main_ok,
  input  logic    pci_rst_n,
  input  logic    go_d3,
  input  logic    go_d0,
  input  logic    cfg_q,
  output pwr_st_e st_q,
  output logic    por_q,
  output logic    phy_rst_q
);
  pwr_st_e nxt;
  logic    por_set, phy_set;

  always_comb begin
    nxt     = st_q;
    por_set = 1'b0;
    phy_set = 1'b0;
    if (!main_ok && !aux_det) begin
      nxt = PS_OFF;
    end else begin
      unique case (st_q)
        PS_OFF: begin
          nxt     = PS_COLD;
          por_set = 1'b1;
        end
        PS_COLD: if (main_ok && pci_rst_n) nxt = PS_D0U;
        default: begin
          if (!main_ok) begin
            nxt     = PS_COLD;
            phy_set = 1'b1;
          end else if (st_q == PS_HOT) begin
            if (go_d0) nxt = PS_D0U;
          end else if (go_d3) begin
            nxt = PS_HOT;
          end else if (st_q == PS_D0U && cfg_q) begin
            nxt = PS_D0A;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= PS_OFF;
      por_q     <= 1'b0;
      phy_rst_q <= 1'b0;
    end else begin
      st_q      <= nxt;
      por_q     <= por_set;
      phy_rst_q <= phy_set;
    end
  end
endmodule

// File: rtl/pwr_wake.sv
`timescale 1ns/1ps
module pwr_wake
  import pwr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           por,
  input  pwr_st_e        st,
  input  logic [ENW-1:0] en_q,
  input  logic           wake_mac,
  input  logic           wake_phy,
  input  logic           wake_clr,
  output logic           int_n,
  output logic           pme_n
);
  logic ev, pme_sts, irq_sts;

  assign ev    = wake_mac || wake_phy;
  assign int_n = !irq_sts;
  assign pme_n = !pme_sts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pme_sts <= 1'b0;
      irq_sts <= 1'b0;
    end else begin
      if (por || wake_clr)                            pme_sts <= 1'b0;
      else if (ev && en_q[EN_PME] && st != PS_OFF)    pme_sts <= 1'b1;

      if (por || wake_clr)                            irq_sts <= 1'b0;
      else if (ev && en_q[EN_IRQ] && st == PS_D0A)    irq_sts <= 1'b1;
    end
  end
endmodule

// File: rtl/pci_pwr_ctl.sv
`timescale 1ns/1ps
module pci_pwr_ctl
  import pwr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           aux_det,
  input  logic           main_ok,
  input  logic           pci_rst_n,
  input  logic           ps_wr,
  input  logic [PSW-1:0] ps_wdata,
  input  logic           en_wr,
  input  logic [ENW-1:0] en_wdata,
  input  logic           cfg_done,
  input  logic           wake_mac,
  input  logic           wake_phy,
  input  logic           wake_clr,
  output logic [STW-1:0] pwr_state,
  output logic [PSW-1:0] ps_rdata,
  output logic           por,
  output logic           phy_pd,
  output logic           phy_rst,
  output logic           mac_en,
  output logic           int_n,
  output logic           pme_n
);
  pwr_st_e        st;
  logic           go_d3, go_d0, cfg_q;
  logic [ENW-1:0] en_q;

  pwr_fsm u_fsm (
    .clk, .rst_n, .aux_det, .main_ok, .pci_rst_n,
    .go_d3, .go_d0, .cfg_q,
    .st_q(st), .por_q(por), .phy_rst_q(phy_rst)
  );

  pwr_fields u_fields (
    .clk, .rst_n, .por, .st, .ps_wr, .ps_wdata, .en_wr, .en_wdata, .cfg_done,
    .go_d3, .go_d0, .ps_q(ps_rdata), .cfg_q, .en_q
  );

  pwr_wake u_wake (
    .clk, .rst_n, .por, .st, .en_q, .wake_mac, .wake_phy, .wake_clr,
    .int_n, .pme_n
  );

  assign pwr_state = st;
  assign phy_pd    = (st == PS_OFF) || (st == PS_COLD);
  assign mac_en    = (st == PS_D0A);
endmodule

// File: rtl/pci_pwr_ctl_chk.sv
`timescale 1ns/1ps
module pci_pwr_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       aux_det,
  input logic       main_ok,
  input logic       ps_wr,
  input logic [1:0] ps_wdata,
  input logic       wake_clr,
  input logic [2:0] pwr_state,
  input logic [1:0] ps_rdata,
  input logic       por,
  input logic       phy_pd,
  input logic       phy_rst,
  input logic       mac_en,
  input logic       pme_n
);
  assert_off_on_power_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_ok && !aux_det) |=> pwr_state == 3'd0);

  assert_sleep_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == 3'd3 || pwr_state == 3'd4) && ps_wr && ps_wdata == 2'b11 && main_ok)
      |=> pwr_state == 3'd2);

  assert_reserved_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd2 && ps_wr && (ps_wdata == 2'b01 || ps_wdata == 2'b10) && main_ok)
      |=> (pwr_state == 3'd2 && ps_rdata == 2'b11));

  assert_d0_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd3 || pwr_state == 3'd4) |-> ps_rdata == 2'b00);

  assert_por_in_cold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    por |-> (pwr_state == 3'd1 && phy_pd));

  assert_phy_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rst |-> (pwr_state == 3'd1 && $past(pwr_state) >= 3'd2));

  assert_mac_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en |-> pwr_state == 3'd4);

  assert_pme_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pme_n && !wake_clr && !por) |=> !pme_n);
endmodule

bind pci_pwr_ctl pci_pwr_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .aux_det(aux_det), .main_ok(main_ok),
  .ps_wr(ps_wr), .ps_wdata(ps_wdata), .wake_clr(wake_clr),
  .pwr_state(pwr_state), .ps_rdata(ps_rdata), .por(por), .phy_pd(phy_pd),
  .phy_rst(phy_rst), .mac_en(mac_en), .pme_n(pme_n)
);

// File: tb/pci_pwr_ctl_bench.sv
`timescale 1ns/1ps
module pci_pwr_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aux_det = 0, main_ok = 0, pci_rst_n = 0, ps_wr = 0, en_wr = 0;
  logic cfg_done = 0, wake_mac = 0, wake_phy = 0, wake_clr = 0;
  logic [1:0] ps_wdata = 0, en_wdata = 0;
  logic [2:0] pwr_state;
  logic [1:0] ps_rdata;
  logic por, phy_pd, phy_rst, mac_en, int_n, pme_n;

  always #2.5 clk = ~clk;

  pci_pwr_ctl u_pci_pwr_ctl (.*);

  typedef struct { string req; int sel; int exp; } item_t;
  item_t q[$];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  function automatic int probe(int sel);
    case (sel)
      0: return int'(pwr_state);
      1: return int'(ps_rdata);
      2: return int'(por);
      3: return int'(phy_pd);
      4: return int'(phy_rst);
      5: return int'(mac_en);
      6: return int'(int_n);
      default: return int'(pme_n);
    endcase
  endfunction

  task automatic put(string r, int sel, int v);
    q.push_back('{r, sel, v});
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = probe(it.sel);
      n_chk++;
      if (act != it.exp) begin
        n_err++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    put("R1", 0, 0); put("R1", 3, 1); put("R1", 5, 0);
    put("R1", 2, 0); put("R1", 6, 1); put("R1", 7, 1);

    aux_det = 1; step();
    put("R2", 0, 1); put("R2", 2, 1); put("R2", 3, 1);
    step();
    put("R2", 2, 0); put("R3", 0, 1);
    main_ok = 1; step();
    put("R3", 0, 1);
    pci_rst_n = 1; step();
    put("R3", 0, 3); put("R4", 3, 0); put("R4", 5, 0); put("R7", 1, 0);

    ps_wr = 1; ps_wdata = 2'b01; step(); ps_wr = 0;
    put("R8", 0, 3); put("R8", 1, 0);

    en_wr = 1; en_wdata = 2'b01; step(); en_wr = 0;
    wake_mac = 1; step(); wake_mac = 0;
    put("R11", 7, 0); put("R12", 6, 1);
    step(); put("R11", 7, 0);
    wake_clr = 1; step(); wake_clr = 0;
    put("R11", 7, 1);

    cfg_done = 1; step(); cfg_done = 0;
    put("R5", 0, 3);
    step(); put("R5", 0, 4); put("R5", 5, 1);

    en_wr = 1; en_wdata = 2'b10; step(); en_wr = 0;
    wake_phy = 1; step(); wake_phy = 0;
    put("R12", 6, 0); put("R11", 7, 1);
    wake_clr = 1; step(); wake_clr = 0;
    put("R12", 6, 1);

    ps_wr = 1; ps_wdata = 2'b11; step();
    put("R6", 0, 2); put("R6", 1, 3); put("R6", 5, 0);
    ps_wdata = 2'b10; step();
    put("R8", 0, 2); put("R8", 1, 3);
    ps_wdata = 2'b00; step(); ps_wr = 0;
    put("R7", 0, 3); put("R7", 1, 0);
    step(); put("R5", 0, 3);

    main_ok = 0; step();
    put("R9", 0, 1); put("R9", 4, 1); put("R9", 3, 1);
    step(); put("R9", 4, 0); put("R9", 0, 1);
    wake_mac = 1; step(); wake_mac = 0;
    put("R12", 6, 1);

    main_ok = 1; step(); put("R3", 0, 3);
    cfg_done = 1; step(); cfg_done = 0;
    step(); put("R5", 0, 4);
    aux_det = 0; main_ok = 0; step();
    put("R10", 0, 0); put("R10", 5, 0);

    aux_det = 1; step(); put("R2", 2, 1);
    step();
    main_ok = 1; step(); put("R13", 0, 3);
    cfg_done = 1; step(); cfg_done = 0;
    step(); put("R13", 0, 4);
    wake_phy = 1; step(); wake_phy = 0;
    put("R13", 6, 1); put("R13", 7, 1);

    aux_det = 0; step(); put("R10", 0, 4);
    main_ok = 0; step(); put("R10", 0, 0);
    main_ok = 1; step(); put("R2", 0, 1); put("R2", 2, 1);
    step(); put("R3", 0, 3);

    @(negedge clk);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule